// File: doc/BRIEF.md
# Power Button Press Classifier with Hold-to-Off Override

This block takes the raw, active-low signal of a power button and turns it into system events. The raw level first crosses into the clock domain through a synchronizer chain. It is then filtered by a debounce counter, so that only a level that stays steady for the whole debounce interval is accepted. Each accepted press is then classified.

A short press becomes an event when it is released. That event depends on the platform state seen at the moment of release. If the system is running, the block raises a request to enter sleep. If the system is in any sleep state, it raises a wake event instead. If the button stays down for the programmed hold time, the block forces soft-off without condition, whatever the current state. The press that fired this override produces nothing more when it is released.

All timing is counted in clock cycles. A prescaler that ticks once per millisecond is built from the parameter giving clock cycles per millisecond. The override hold time is supplied in milliseconds on an input port.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: A change of the raw button level is accepted only after the synchronized level has differed from the accepted level for DEB_MS*CYC_PER_MS consecutive cycles. A pulse or glitch shorter than that produces no event.
- R2: A short press released while sys_state_i is 0 (running) gives one sleep_req_o pulse, 3+DEB_MS*CYC_PER_MS cycles after the raw release.
- R3: A short press released while sys_state_i is 1, 2 or 3 (suspend to RAM, suspend to disk, soft-off) gives one wake_o pulse, with the same timing as R2. The state is taken at release, not at press.
- R4: A press held for L milliseconds gives one force_off_o pulse, 3+DEB_MS*CYC_PER_MS+L*CYC_PER_MS cycles after the raw press. L is the override time in effect for that press.
- R5: The forced soft-off fires in every value of sys_state_i, including 1 and 2.
- R6: ovr_ms_i is sampled once, in the cycle after the debounced press is accepted. Later changes during the same press have no effect.
- R7: Releasing a press whose override has already fired produces neither sleep_req_o nor wake_o.
- R8: An override time of 0 is treated as 1 millisecond.
- R9: Every output is a one-cycle pulse. At most one output is high in any cycle, and each debounced press yields exactly one event.
- R10: While rst_ni is low and after it is released, all outputs are low and the button is treated as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_btn_ni | input | 1 | Raw button level, low while pressed, asynchronous |
| sys_state_i | input | 2 | Current platform state: 0 running, 1 suspend to RAM, 2 suspend to disk, 3 soft-off |
| ovr_ms_i | input | OVR_W | Hold time for the forced soft-off, in milliseconds |
| sleep_req_o | output | 1 | One-cycle request to enter sleep |
| wake_o | output | 1 | One-cycle wake event |
| force_off_o | output | 1 | One-cycle forced soft-off event |

## Verification
Let D be the debounce length in cycles and C the number of cycles per millisecond. Count edges from the first rising clock edge after the raw input changes. The sleep and wake pulses are visible after edge 2+D from the raw release. The forced soft-off is visible after edge 2+D+L*C from the raw press. The driver computes each due cycle from these formulas and queues it, together with the expected event kind. The monitor compares every pulse against the queue head at the falling edge, and checks the exact cycle, not a window. Windows that must stay silent, such as glitches and the release after an override, are checked by counting any pulse that arrives with no entry queued.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_RAM  = 2'd1,
      ST_DISK = 2'd2,
      ST_OFF  = 2'd3
   } sys_state_e;

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_SLEEP = 2'd1,
      EV_WAKE  = 2'd2,
      EV_OFF   = 2'd3
   } btn_event_e;

endpackage

// File: rtl/pwrbtn_sync.sv
module pwrbtn_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= RESET_VAL;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= RESET_VAL;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwrbtn_debounce.sv
module pwrbtn_debounce #(
   parameter int unsigned STEADY_CYC = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic pressed_o,
   output logic press_p_o,
   output logic release_p_o
);

   localparam int unsigned CW = $clog2(STEADY_CYC);
   localparam logic [CW-1:0] LAST = CW'(STEADY_CYC - 1);

   logic          stable_q;
   logic [CW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stable_q    <= 1'b1;
         run_q       <= '0;
         press_p_o   <= 1'b0;
         release_p_o <= 1'b0;
      end else begin
         press_p_o   <= 1'b0;
         release_p_o <= 1'b0;
         if (lvl_i == stable_q) begin
            run_q <= '0;
         end else if (run_q == LAST) begin
            run_q       <= '0;
            stable_q    <= lvl_i;
            press_p_o   <= ~lvl_i;
            release_p_o <= lvl_i;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign pressed_o = ~stable_q;

   // R1: a flip of the accepted level follows at least two cycles of the new level
   a_r1_steady_before_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stable_q != $past(stable_q)) |-> ($past(lvl_i) == stable_q && $past(lvl_i, 2) == stable_q));

   // R9: press and release pulses never coincide
   a_r9_edge_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(press_p_o && release_p_o));

endmodule

// File: rtl/pwrbtn_hold.sv
module pwrbtn_hold
   import pwrbtn_pkg::*;
#(
   parameter int unsigned CYC_PER_MS = 100000,
   parameter int unsigned OVR_W      = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             press_p_i,
   input  logic             release_p_i,
   input  logic [1:0]       state_i,
   input  logic [OVR_W-1:0] ovr_ms_i,
   output logic             sleep_req_o,
   output logic             wake_o,
   output logic             force_off_o
);

   localparam int unsigned PW = $clog2(CYC_PER_MS);
   localparam logic [PW-1:0]    PRE_LAST = PW'(CYC_PER_MS - 1);
   localparam logic [OVR_W-1:0] ONE_MS   = OVR_W'(1);

   sys_state_e       state;
   logic             holding_q;
   logic             fired_q;
   logic [PW-1:0]    pre_q;
   logic [OVR_W-1:0] ms_q;
   logic [OVR_W-1:0] limit_q;
   logic [OVR_W-1:0] ms_next;

   assign state   = sys_state_e'(state_i);
   assign ms_next = ms_q + ONE_MS;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         holding_q   <= 1'b0;
         fired_q     <= 1'b0;
         pre_q       <= '0;
         ms_q        <= '0;
         limit_q     <= ONE_MS;
         sleep_req_o <= 1'b0;
         wake_o      <= 1'b0;
         force_off_o <= 1'b0;
      end else begin
         sleep_req_o <= 1'b0;
         wake_o      <= 1'b0;
         force_off_o <= 1'b0;
         if (press_p_i) begin
            holding_q <= 1'b1;
            fired_q   <= 1'b0;
            pre_q     <= '0;
            ms_q      <= '0;
            limit_q   <= (ovr_ms_i == '0) ? ONE_MS : ovr_ms_i;
         end else if (release_p_i) begin
            holding_q <= 1'b0;
            if (holding_q && !fired_q) begin
               if (state == ST_RUN) sleep_req_o <= 1'b1;
               else                 wake_o      <= 1'b1;
            end
         end else if (holding_q && !fired_q) begin
            if (pre_q == PRE_LAST) begin
               pre_q <= '0;
               ms_q  <= ms_next;
               if (ms_next == limit_q) begin
                  fired_q     <= 1'b1;
                  force_off_o <= 1'b1;
               end
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end
      end
   end

   // R9: one event at a time
   a_r9_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({sleep_req_o, wake_o, force_off_o}));

   // R9: every event lasts exactly one cycle
   a_r9_pulse_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_req_o |=> !sleep_req_o);
   a_r9_pulse_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |=> !wake_o);
   a_r9_pulse_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_off_o |=> !force_off_o);

   // R2: sleep request only when running at release
   a_r2_sleep_when_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_req_o |-> ($past(state_i) == 2'd0 && $past(release_p_i)));

   // R3: wake only from a sleep state at release
   a_r3_wake_when_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> ($past(state_i) != 2'd0 && $past(release_p_i)));

   // R4: soft-off only during a held press
   a_r4_off_while_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_off_o |-> ($past(holding_q) && !$past(release_p_i)));

   // R7: no short-press event after the override fired
   a_r7_quiet_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_req_o || wake_o) |-> !$past(fired_q));

endmodule

// File: rtl/pwrbtn_ctrl.sv
module pwrbtn_ctrl
   import pwrbtn_pkg::*;
#(
   parameter int unsigned CYC_PER_MS  = 100000,
   parameter int unsigned DEB_MS      = 16,
   parameter int unsigned OVR_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pwr_btn_ni,
   input  logic [1:0]       sys_state_i,
   input  logic [OVR_W-1:0] ovr_ms_i,
   output logic             sleep_req_o,
   output logic             wake_o,
   output logic             force_off_o
);

   localparam int unsigned DEB_CYC = DEB_MS * CYC_PER_MS;

   generate
      if (CYC_PER_MS < 2) begin : g_bad_ms
         $error("CYC_PER_MS must be at least 2");
      end
      if (DEB_CYC < 2) begin : g_bad_deb
         $error("debounce interval must be at least 2 cycles");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (OVR_W < 1) begin : g_bad_w
         $error("OVR_W must be at least 1");
      end
   endgenerate

   logic btn_sync;
   logic pressed;
   logic press_p;
   logic release_p;

   pwrbtn_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pwr_btn_ni),
      .q_o    (btn_sync)
   );

   pwrbtn_debounce #(
      .STEADY_CYC (DEB_CYC)
   ) i_debounce (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lvl_i       (btn_sync),
      .pressed_o   (pressed),
      .press_p_o   (press_p),
      .release_p_o (release_p)
   );

   pwrbtn_hold #(
      .CYC_PER_MS (CYC_PER_MS),
      .OVR_W      (OVR_W)
   ) i_hold (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .press_p_i   (press_p),
      .release_p_i (release_p),
      .state_i     (sys_state_i),
      .ovr_ms_i    (ovr_ms_i),
      .sleep_req_o (sleep_req_o),
      .wake_o      (wake_o),
      .force_off_o (force_off_o)
   );

   // R1: a press is accepted only while the accepted level shows the button down
   a_r1_press_matches_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      press_p |-> pressed);

   // R10: nothing fires in the first cycle after reset
   a_r10_quiet_after_reset: assert property (@(posedge clk_i)
      !rst_ni |=> !(sleep_req_o || wake_o || force_off_o));

endmodule

// File: tb/test_pwrbtn_ctrl.sv
module test_pwrbtn_ctrl;

   localparam int unsigned CPM  = 4;
   localparam int unsigned DMS  = 2;
   localparam int unsigned DEB  = CPM * DMS;
   localparam int unsigned OW   = 8;
   localparam int K_SLEEP = 1;
   localparam int K_WAKE  = 2;
   localparam int K_OFF   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          btn_n = 1'b1;
   logic [1:0]    state = 2'd0;
   logic [OW-1:0] ovr = 8'd10;
   logic          sleep_req, wake, force_off;

   int cyc = 0;
   int vectors = 0;
   int fails = 0;
   int spurious = 0;
   int exp_kind[$];
   int exp_due[$];
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwrbtn_ctrl #(
      .CYC_PER_MS  (CPM),
      .DEB_MS      (DMS),
      .OVR_W       (OW),
      .SYNC_STAGES (2)
   ) i_pwrbtn_ctrl (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .pwr_btn_ni  (btn_n),
      .sys_state_i (state),
      .ovr_ms_i    (ovr),
      .sleep_req_o (sleep_req),
      .wake_o      (wake),
      .force_off_o (force_off)
   );

   // monitor: pops the expected event and compares kind and cycle
   always @(negedge clk) begin
      if (rst_n && (sleep_req || wake || force_off)) begin
         int kind;
         kind = force_off ? K_OFF : (wake ? K_WAKE : K_SLEEP);
         if ($countones({sleep_req, wake, force_off}) > 1) begin
            vectors++; fails++;
            $display("FAIL R9: several outputs high at cycle %0d, got %b expected one-hot",
                     cyc, {force_off, wake, sleep_req});
         end
         if (exp_kind.size() == 0) begin
            spurious++;
         end else begin
            int ek, ed;
            ek = exp_kind.pop_front();
            ed = exp_due.pop_front();
            vectors++;
            if (ek != kind || ed != cyc) begin
               fails++;
               $display("FAIL R2/R3/R4 event: got kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                        kind, cyc, ek, ed);
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic quiet(input int n, input string req);
      int s0;
      s0 = spurious;
      repeat (n) @(negedge clk);
      check(spurious == s0, req, spurious - s0, 0);
   endtask

   // driver: press for 'hold' cycles, queue what the requirements predict
   task automatic tap(input int hold, input int lim, input bit is_long, input int kind,
                      input int mid_at, input int mid_state, input int mid_ovr);
      int c0, r0;
      @(negedge clk);
      c0 = cyc;
      btn_n = 1'b0;
      if (is_long) begin
         exp_kind.push_back(K_OFF);
         exp_due.push_back(c0 + 3 + DEB + lim * CPM);
      end
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         if (i == mid_at) begin
            if (mid_state >= 0) state = mid_state[1:0];
            if (mid_ovr >= 0)   ovr   = mid_ovr[OW-1:0];
         end
      end
      r0 = cyc;
      btn_n = 1'b1;
      if (!is_long) begin
         exp_kind.push_back(kind);
         exp_due.push_back(r0 + 3 + DEB);
      end
      repeat (DEB + 8) @(negedge clk);
      check(exp_kind.size() == 0, "R9 one event per press", exp_kind.size(), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R10: outputs low during reset
      check({sleep_req, wake, force_off} == 3'b000, "R10 in reset", {sleep_req, wake, force_off}, 0);
      rst_n = 1'b1;
      quiet(20, "R10 after reset");

      // R2: short press while running
      state = 2'd0; ovr = 8'd10;
      tap(20, 10, 1'b0, K_SLEEP, -1, -1, -1);
      // R3: short press in each sleep state
      state = 2'd1; tap(20, 10, 1'b0, K_WAKE, -1, -1, -1);
      state = 2'd2; tap(15, 10, 1'b0, K_WAKE, -1, -1, -1);
      state = 2'd3; tap(25, 10, 1'b0, K_WAKE, -1, -1, -1);

      // R1: glitches shorter than the debounce interval
      state = 2'd0;
      @(negedge clk); btn_n = 1'b0;
      repeat (5) @(negedge clk); btn_n = 1'b1;
      repeat (2) @(negedge clk); btn_n = 1'b0;
      repeat (DEB - 2) @(negedge clk); btn_n = 1'b1;
      quiet(40, "R1 glitch ignored");

      // R1/R9: chatter before a steady press gives a single event
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); btn_n = 1'b0;
         repeat (2) @(negedge clk); btn_n = 1'b1;
      end
      tap(20, 10, 1'b0, K_SLEEP, -1, -1, -1);

      // R4/R7: long hold while running, no event on release
      state = 2'd0; ovr = 8'd10;
      tap(70, 10, 1'b1, K_OFF, -1, -1, -1);
      quiet(10, "R7 release after override");

      // R5: long hold while in suspend to RAM and suspend to disk
      state = 2'd1; ovr = 8'd5;
      tap(50, 5, 1'b1, K_OFF, -1, -1, -1);
      state = 2'd2; ovr = 8'd3;
      tap(40, 3, 1'b1, K_OFF, -1, -1, -1);

      // R6: changing the override time mid-press has no effect
      state = 2'd0; ovr = 8'd10;
      tap(70, 10, 1'b1, K_OFF, 20, -1, 2);
      quiet(10, "R6 mid-press change");

      // R8: zero override time acts as one millisecond
      ovr = 8'd0;
      tap(40, 1, 1'b1, K_OFF, -1, -1, -1);

      // R3: state taken at release, not at press
      state = 2'd0; ovr = 8'd10;
      tap(24, 10, 1'b0, K_WAKE, 10, 2, -1);

      quiet(20, "R9 trailing silence");
      check(spurious == 0, "R9 no unexpected pulse", spurious, 0);
      check(exp_kind.size() == 0, "R9 no missing event", exp_kind.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         vectors++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule